// File: doc/BRIEF.md
# Buffered PWM Channel Generator

This block produces one pulse-width-modulated waveform from a free-running counter. A small register port configures it. A mode register picks the tick rate of the counter, edge or center alignment, the level at which each period begins, and which timing value a buffered write replaces. While the channel is disabled, the duty and period values can be loaded directly. While it runs, new timing values are parked in an update buffer and copied over only when a new period starts, so the waveform never carries a half-changed period.

The counter is readable at any time. A one-cycle strobe marks the clock edge at which a new period begins.

Top module: `pwm_channel`

## Requirements
- R1: After reset, every register (mode 0x00, duty 0x04, period 0x08, counter 0x0C, update 0x10) reads zero and period_start is low.
- R2: The counter advances once every 2^k clocks while enabled, where k is mode bits 3:0. k saturates at PRE_MAX (default 10), so the value 15 gives one advance per 1024 clocks.
- R3: With mode bit 8 clear (edge-aligned), the counter runs 0, 1, ..., P-1 and then wraps to 0, giving P ticks per period. P is the period value, and a period value of 0 behaves as 1.
- R4: With mode bit 8 set (center-aligned), the counter runs up from 0 to P and back down to 1 before it returns to 0, giving 2P ticks per period.
- R5: Mode bit 9 is the starting level. The output shows that level while the counter is below the duty value D on the way up, or at or below D on the way down, and shows the opposite level otherwise. D=0 gives a constant opposite level, and D=P gives a constant starting level.
- R6: period_start is high during the cycle whose next clock edge returns the counter to 0 from the end of a period.
- R7: Writes to the mode, duty and period registers take effect only while chan_en is low. While the channel runs they are ignored, and the registers read back unchanged.
- R8: A write to the update register (0x10) is stored and reads back at 0x10. At the next period start it replaces the duty value (mode bit 10 = 0) or the period value (mode bit 10 = 1). The target register is unchanged until that edge.
- R9: The counter reads at 0x0C, and it returns to 0 one edge after chan_en falls. Undefined bits read zero: the mode register keeps only bits 3:0, 8, 9 and 10, and duty and period keep 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel run enable; low holds the counter at zero |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | PWM waveform |
| period_start | output | 1 | Period boundary strobe |

## Verification
Assertions check on every cycle that the counter stays within the period, moves by exactly one step per tick and holds otherwise, and sits at zero after a disable. They also check that running-state writes never alter duty, period or mode outside a period start, that the pending flag clears after a transfer, and that the extreme duty values pin the output level. The counter sequence for each alignment, the output level at every tick, the strobe timing, and the deferred application of buffered values can only be shown by the bench. It sweeps every duty value for small periods in both alignments and both polarities and compares each cycle with an arithmetic model.

// File: rtl/pwmc_pkg.sv
// Shared types and register addresses for the PWM channel.
// Assumes a 5-bit byte address with word-aligned registers.
package pwmc_pkg;
    typedef struct packed {
        logic       tgt_prd;   // buffered write target: 0 duty, 1 period
        logic       pol;       // starting level of each period
        logic       center;    // 0 edge aligned, 1 center aligned
        logic [3:0] pre;       // tick rate exponent
    } pwmc_mode_t;

    localparam logic [4:0] A_MODE = 5'h00;
    localparam logic [4:0] A_DUTY = 5'h04;
    localparam logic [4:0] A_PRD  = 5'h08;
    localparam logic [4:0] A_CNT  = 5'h0C;
    localparam logic [4:0] A_UPD  = 5'h10;
endpackage

// File: rtl/pwmc_prescaler.sv
// Clock-enable generator: emits one tick every 2^k clocks while enabled.
// Assumes pre only changes while en is low; k saturates at PRE_MAX.
module pwmc_prescaler #(
    parameter int PRE_MAX = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [3:0] pre,
    output logic       tick
);
    logic [PRE_MAX-1:0] div_q;
    logic [3:0]         k_eff;
    logic [PRE_MAX:0]   one_hot;
    logic [PRE_MAX-1:0] mask;

    // Clamp the requested exponent and build the low-bit mask.
    always_comb begin
        k_eff   = (pre > 4'(PRE_MAX)) ? 4'(PRE_MAX) : pre;
        one_hot = (PRE_MAX+1)'(1) << k_eff;
        mask    = one_hot[PRE_MAX-1:0] - {{(PRE_MAX-1){1'b0}}, 1'b1};
        tick    = en && ((div_q & mask) == mask);
    end

    // Free-running divider, cleared while the channel is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    // With a nonzero exponent two ticks never arrive back to back.
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && k_eff != 4'd0) |=> !tick);
endmodule

// File: rtl/pwmc_counter.sv
// Channel counter: edge-aligned wrap or center-aligned up/down count.
// Assumes center and prd change only while disabled or at a period start.
module pwmc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             center,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             up,
    output logic             pstart
);
    logic [CNT_W-1:0] prd_eff;
    logic [CNT_W:0]   cnt_inc;
    logic             top_hit;
    logic             at_end;

    // Next-step decode: peak reached and end of period.
    always_comb begin
        prd_eff = (prd == '0) ? CNT_W'(1) : prd;
        cnt_inc = {1'b0, cnt} + 1'b1;
        top_hit = cnt_inc >= {1'b0, prd_eff};
        at_end  = center ? (!up && cnt <= CNT_W'(1)) : top_hit;
        pstart  = tick && at_end;
    end

    // Count state update on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (tick) begin
            if (!center) begin
                cnt <= top_hit ? '0 : cnt_inc[CNT_W-1:0];
            end else if (up) begin
                if (top_hit) begin
                    cnt <= prd_eff;
                    up  <= 1'b0;
                end else begin
                    cnt <= cnt_inc[CNT_W-1:0];
                end
            end else if (cnt <= CNT_W'(1)) begin
                cnt <= '0;
                up  <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (center ? cnt <= prd_eff : cnt < prd_eff));
    assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0);
    assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pstart && prd_eff != CNT_W'(1)) |=>
            (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(cnt));
endmodule

// File: rtl/pwmc_regs.sv
// Register file with the update double buffer and combinational read mux.
// Direct timing and mode writes are accepted only while the channel is off.
module pwmc_regs
    import pwmc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pstart,
    input  logic [4:0]        addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    output pwmc_mode_t        mode,
    output logic [CNT_W-1:0]  duty,
    output logic [CNT_W-1:0]  prd,
    output logic [DATA_W-1:0] rdata
);
    logic [CNT_W-1:0] upd_q;
    logic             pend_q;
    logic             wr_direct;
    logic             wr_upd;

    // Decode write classes.
    always_comb begin
        wr_direct = wr && !en;
        wr_upd    = wr && (addr == A_UPD);
    end

    // Mode register, writable only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= '0;
        else if (wr_direct && addr == A_MODE)
            mode <= '{tgt_prd: wdata[10], pol: wdata[9],
                      center: wdata[8], pre: wdata[3:0]};
    end

    // Duty register: direct load when stopped, buffered load at period start.
    always_ff @(posedge clk) begin
        if (!rst_n) duty <= '0;
        else if (wr_direct && addr == A_DUTY) duty <= wdata[CNT_W-1:0];
        else if (pstart && pend_q && !mode.tgt_prd) duty <= upd_q;
    end

    // Period register: direct load when stopped, buffered load at period start.
    always_ff @(posedge clk) begin
        if (!rst_n) prd <= '0;
        else if (wr_direct && addr == A_PRD) prd <= wdata[CNT_W-1:0];
        else if (pstart && pend_q && mode.tgt_prd) prd <= upd_q;
    end

    // Update buffer and its pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q  <= '0;
            pend_q <= 1'b0;
        end else if (wr_upd) begin
            upd_q  <= wdata[CNT_W-1:0];
            pend_q <= 1'b1;
        end else if (pstart) begin
            pend_q <= 1'b0;
        end
    end

    // Read mux; undefined bits return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE: begin
                rdata[3:0] = mode.pre;
                rdata[8]   = mode.center;
                rdata[9]   = mode.pol;
                rdata[10]  = mode.tgt_prd;
            end
            A_DUTY:  rdata[CNT_W-1:0] = duty;
            A_PRD:   rdata[CNT_W-1:0] = prd;
            A_CNT:   rdata[CNT_W-1:0] = cnt;
            A_UPD:   rdata[CNT_W-1:0] = upd_q;
            default: rdata = '0;
        endcase
    end

    assert_run_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !pstart) |=> ($stable(duty) && $stable(prd) && $stable(mode)));
    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pstart && !wr_upd) |=> !pend_q);
endmodule

// File: rtl/pwmc_compare.sv
// Output stage: compares the counter with the duty value and applies polarity.
// Combinational; clk and rst_n are used only by the assertion.
module pwmc_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             up,
    input  logic [CNT_W-1:0] duty,
    input  logic             pol,
    output logic             out
);
    logic active;

    // Starting level is shown while the counter sits inside the duty window.
    always_comb begin
        active = up ? (cnt < duty) : (cnt <= duty);
        out    = active ? pol : !pol;
    end

    assert_duty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |-> (out == !pol));
endmodule

// File: rtl/pwm_channel.sv
// Single buffered PWM channel: prescaler, counter, registers, compare.
// Assumes the register port is driven synchronously to clk.
module pwm_channel
    import pwmc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRE_MAX = 10,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [4:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out,
    output logic              period_start
);
    pwmc_mode_t       mode;
    logic [CNT_W-1:0] duty;
    logic [CNT_W-1:0] prd;
    logic [CNT_W-1:0] cnt;
    logic             up;
    logic             tick;
    logic             pstart;

    pwmc_prescaler #(.PRE_MAX(PRE_MAX)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(chan_en), .pre(mode.pre), .tick(tick)
    );

    pwmc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(chan_en), .tick(tick),
        .center(mode.center), .prd(prd), .cnt(cnt), .up(up), .pstart(pstart)
    );

    pwmc_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .en(chan_en), .pstart(pstart),
        .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata), .cnt(cnt),
        .mode(mode), .duty(duty), .prd(prd), .rdata(bus_rdata)
    );

    pwmc_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .up(up), .duty(duty),
        .pol(mode.pol), .out(pwm_out)
    );

    assign period_start = pstart;

    assert_duty_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prd != '0 && duty == prd) |-> (pwm_out == mode.pol));
endmodule

// File: tb/pwm_channel_tb.sv
module pwm_channel_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic [4:0]  bus_addr = 5'h0C;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;
    logic        period_start;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    pwm_channel u_dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .period_start(period_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Starts and ends at a negedge; the write lands on the posedge between.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        bus_addr = a; #1;
        v = int'(bus_rdata);
    endtask

    // Configure while stopped, run, and compare every cycle with the model.
    task automatic run_cfg(input int center, input int pol, input int prd,
                           input int duty, input int k, input int nedges,
                           input string cnt_req);
        int keff, p, plen, n, m, ecnt, estart, tick_now, v;
        chan_en = 1'b0;
        wr(5'h00, (center << 8) | (pol << 9) | k);
        wr(5'h04, duty);
        wr(5'h08, prd);
        bus_addr = 5'h0C;
        chan_en = 1'b1;
        keff = (k > 10) ? 10 : k;
        p    = (prd == 0) ? 1 : prd;
        plen = center ? 2 * p : p;
        for (int j = 0; j < nedges; j++) begin
            #1;
            n = j >> keff;
            m = n % plen;
            if (!center || m < p) begin
                ecnt   = m;
                estart = (m < duty) ? 1 : 0;
            end else begin
                ecnt   = 2 * p - m;
                estart = (ecnt <= duty) ? 1 : 0;
            end
            tick_now = (((j + 1) % (1 << keff)) == 0) ? 1 : 0;
            rd(5'h0C, v);
            check(cnt_req, "counter", v, ecnt);
            check("R5", "pwm_out", int'(pwm_out), estart ? pol : 1 - pol);
            check("R6", "period_start", int'(period_start),
                  (tick_now && (((j + 1) >> keff) % plen) == 0) ? 1 : 0);
            @(negedge clk);
        end
        chan_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(5'h00, v); check("R1", "mode", v, 0);
        rd(5'h04, v); check("R1", "duty", v, 0);
        rd(5'h08, v); check("R1", "period", v, 0);
        rd(5'h0C, v); check("R1", "counter", v, 0);
        rd(5'h10, v); check("R1", "update", v, 0);
        check("R1", "period_start", int'(period_start), 0);
        check("R5", "pwm_out at reset", int'(pwm_out), 1);
        @(negedge clk);

        // R3 R4 R5 R6 sweep over alignment, polarity, period and duty
        for (int c = 0; c < 2; c++)
            for (int pl = 0; pl < 2; pl++)
                for (int pr = 0; pr <= 5; pr++)
                    for (int d = 0; d <= pr; d++)
                        run_cfg(c, pl, pr, d, 0, 2 * (c ? 2 * (pr ? pr : 1) : (pr ? pr : 1)) + 1,
                                c ? "R4" : "R3");

        // R2 divided tick rates, including a saturated exponent
        run_cfg(0, 0, 5, 2, 2, 45, "R2");
        run_cfg(1, 1, 3, 1, 1, 26, "R2");
        run_cfg(0, 0, 3, 1, 15, 2060, "R2");

        // R9 counter clears after disable, undefined bits read zero
        @(negedge clk);
        rd(5'h0C, v); check("R9", "counter after disable", v, 0);
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, v); check("R9", "mode field mask", v, 32'h0000_070F);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, v); check("R9", "duty width", v, 32'h0000_FFFF);

        // R8 buffered duty update, R7 running writes ignored
        wr(5'h00, 32'h0);
        wr(5'h08, 4);
        wr(5'h04, 1);
        chan_en = 1'b1;                 // j=0
        @(negedge clk);                 // j=1
        wr(5'h10, 3);                   // j=2
        rd(5'h04, v); check("R8", "duty before boundary", v, 1);
        rd(5'h10, v); check("R8", "update readback", v, 3);
        rd(5'h0C, v); check("R9", "counter readback", v, 2);
        wr(5'h04, 2);                   // j=3
        rd(5'h04, v); check("R7", "duty write while running", v, 1);
        check("R6", "strobe before wrap", int'(period_start), 1);
        wr(5'h00, 32'h200);             // j=4
        rd(5'h00, v); check("R7", "mode write while running", v, 0);
        rd(5'h04, v); check("R8", "duty after boundary", v, 3);
        check("R8", "out new period start", int'(pwm_out), 0);
        @(negedge clk); @(negedge clk); // j=6
        check("R8", "out inside new duty", int'(pwm_out), 0);
        @(negedge clk);                 // j=7
        check("R8", "out past new duty", int'(pwm_out), 1);
        chan_en = 1'b0;

        // R8 buffered period update
        @(negedge clk);
        wr(5'h00, 32'h400);
        wr(5'h08, 4);
        wr(5'h04, 2);
        chan_en = 1'b1;                 // j=0
        @(negedge clk);                 // j=1
        wr(5'h10, 6);                   // j=2
        rd(5'h08, v); check("R8", "period before boundary", v, 4);
        rd(5'h04, v); check("R8", "duty untouched", v, 2);
        @(negedge clk); @(negedge clk); // j=4
        rd(5'h08, v); check("R8", "period after boundary", v, 6);
        rd(5'h0C, v); check("R8", "counter restart", v, 0);
        repeat (5) @(negedge clk);      // j=9
        rd(5'h0C, v); check("R8", "counter reaches new top", v, 5);
        @(negedge clk);                 // j=10
        rd(5'h0C, v); check("R8", "counter wraps at new period", v, 0);
        chan_en = 1'b0;
        @(negedge clk);
        report();
    end
endmodule